// File: doc/BRIEF.md
# CAN Nominal Bit Timing Engine

This block turns the system clock into time-quantum ticks using a programmable divider. It divides each nominal bit into a one-quantum synchronization slot, a first phase segment and a second phase segment. It watches the received line for recessive-to-dominant transitions and pulls its bit boundaries into step with the other nodes on the bus. When hard synchronization is allowed, a transition restarts the bit at once. Otherwise a transition moves the current bit's sample point later, or ends the bit earlier. The size of that move is limited by a programmable jump width.

Two strobes go to the protocol layer. The first marks the start of each bit and is the moment to launch the next transmit bit. The second marks the sample point and carries the received value. That value is either a single sample or a two-of-three vote. The protocol layer drives the hard-sync permission, typically while the bus is idle. When the timing fields form an illegal combination, the block flags an error and stays idle.

Top module: `can_bit_timing`

## Requirements
- R1: One quantum lasts `brp_cfg`+1 clocks. With no bus activity, consecutive `tx_strobe` pulses are (1 + T1 + T2) quanta apart, where T1 = `ts1_cfg`+1 and T2 = `ts2_cfg`+1.
- R2: `smp_strobe` pulses for one clock, (1 + T1 + E) quanta after the `tx_strobe` of the same bit, where E is that bit's segment-1 extension (0 when no resynchronization happens). It never coincides with `tx_strobe`.
- R3: `tx_strobe` is a one-clock pulse in the first clock of the synchronization quantum.
- R4: A configuration is legal only when `ts1_cfg` ≥ 3, `ts2_cfg` ≥ 1, `ts2_cfg` ≥ `sjw_cfg` and `ts1_cfg` > `ts2_cfg`. An illegal configuration drives `cfg_err` high within two clocks. While `cfg_err` is high, neither strobe pulses.
- R5: A falling edge of `rx_in` (1 = recessive, 0 = dominant) inside quantum q (counting from 0) of segment 1 lengthens segment 1 by min(q+1, J) quanta, where J = `sjw_cfg`+1.
- R6: A falling edge inside quantum q of segment 2 shortens segment 2 by min(T2−q−1, J) quanta. An edge in the last quantum of segment 2 therefore changes nothing.
- R7: At most one resynchronization takes place per bit. Edges that fall in the synchronization quantum are ignored and do not use up the bit's single resynchronization.
- R8: While `hsync_en` is high, a falling edge restarts the bit with no limit on the adjustment. `tx_strobe` pulses in the clock after the edge, and the restarted bit has nominal timing.
- R9: When `smp_mode` = 0, `smp_val` is the value of `rx_in` at the end of the last quantum of segment 1. `smp_val` changes only together with `smp_strobe`.
- R10: When `smp_mode` = 1, `smp_val` is the majority of `rx_in` taken at the ends of the last three quanta of segment 1.
- R11: During reset, `tx_strobe` and `smp_strobe` are low and `smp_val` is 1.
- R12: A rising edge of `rx_in` never changes the bit timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Received bus level, 1 = recessive |
| hsync_en | input | 1 | Allows hard synchronization on the next falling edge |
| brp_cfg | input | 6 | Quantum divider, quantum = value+1 clocks |
| ts1_cfg | input | 4 | Segment 1 length minus one |
| ts2_cfg | input | 3 | Segment 2 length minus one |
| sjw_cfg | input | 2 | Jump width minus one |
| smp_mode | input | 1 | 0 = single sample, 1 = three-sample majority |
| cfg_err | output | 1 | Illegal timing configuration, block held idle |
| tx_strobe | output | 1 | Start-of-bit pulse |
| smp_strobe | output | 1 | Sample-point pulse |
| smp_val | output | 1 | Value taken at the latest sample point |

## Verification
A set of divider and segment settings is run with the line held recessive. This separates the quantum divider from the segment lengths, since both the bit period and the sample offset are measured. Falling edges are then placed in early and late quanta of each segment. These placements tell apart a phase error that stays under the jump width from one that is clipped by it, and a lengthened segment 1 from a shortened segment 2. Further patterns cover a second edge in the same bit, an edge in the synchronization quantum, a lone rising edge, a hard-sync edge late in a bit, and a short recessive pulse near the sample point. The last of these reads differently under single sampling and under the vote.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int BRP_W     = 6;
  localparam int TS1_W     = 4;
  localparam int TS2_W     = 3;
  localparam int SJW_W     = 2;
  localparam int TS1_MIN   = 3;
  localparam int TS2_MIN   = 1;
  localparam int T1_LEN_W  = TS1_W + 1;
  localparam int T2_LEN_W  = TS2_W + 1;
  localparam int SJW_LEN_W = SJW_W + 1;
  localparam int MAX_EXT   = 1 << SJW_W;
  localparam int QCNT_W    = $clog2((1 << TS1_W) + MAX_EXT) + 1;
  localparam int MAX_BIT_Q = 1 + (1 << TS1_W) + (1 << TS2_W) + MAX_EXT;
  localparam int MAX_BIT_CLK = MAX_BIT_Q * (1 << BRP_W);

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_TS1  = 2'd1,
    SEG_TS2  = 2'd2
  } seg_e;
endpackage

// File: rtl/can_bt_presc.sv
module can_bt_presc
  import can_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [BRP_W-1:0] div,
  output logic             tick
);
  logic [BRP_W-1:0] cnt_q, cnt_n;

  assign tick = run && (cnt_q == div);

  always_comb begin
    cnt_n = cnt_q;
    if (!run || restart || tick) cnt_n = '0;
    else                         cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 tick,
  input  logic                 edge_fall,
  input  logic                 hs_en,
  input  logic [T1_LEN_W-1:0]  t1_len,
  input  logic [T2_LEN_W-1:0]  t2_len,
  input  logic [SJW_LEN_W-1:0] sjw_len,
  output logic                 restart,
  output logic                 ts1_tick,
  output logic                 smp_tick,
  output logic                 tx_q
);
  seg_e              seg_q, seg_n;
  logic [QCNT_W-1:0] qcnt_q, qcnt_n;
  logic [QCNT_W-1:0] ext_q, ext_n, shr_q, shr_n;
  logic              done_q, done_n;
  logic              enter_sync;

  logic [QCNT_W-1:0] sjw_x, err_pos, err_neg, adj_pos, adj_neg;
  logic [QCNT_W-1:0] t1_eff, t2_eff, q_inc;
  logic              rs_pos, rs_neg, rs_any;

  assign restart = run && hs_en && edge_fall;
  assign rs_any  = run && !hs_en && edge_fall && !done_q;
  assign rs_pos  = rs_any && (seg_q == SEG_TS1);
  assign rs_neg  = rs_any && (seg_q == SEG_TS2);

  assign sjw_x   = QCNT_W'(sjw_len);
  assign q_inc   = qcnt_q + 1'b1;
  assign err_pos = q_inc;
  assign err_neg = QCNT_W'(t2_len) - q_inc;
  assign adj_pos = (err_pos < sjw_x) ? err_pos : sjw_x;
  assign adj_neg = (err_neg < sjw_x) ? err_neg : sjw_x;

  assign t1_eff = QCNT_W'(t1_len) + ext_n;
  assign t2_eff = QCNT_W'(t2_len) - shr_n;

  // phase adjustment of the running bit
  always_comb begin
    ext_n  = rs_pos ? (ext_q + adj_pos) : ext_q;
    shr_n  = rs_neg ? (shr_q + adj_neg) : shr_q;
    done_n = done_q | rs_pos | rs_neg;
  end

  // segment stepping
  always_comb begin
    seg_n      = seg_q;
    qcnt_n     = qcnt_q;
    enter_sync = 1'b0;
    ts1_tick   = 1'b0;
    smp_tick   = 1'b0;
    if (!run || restart) begin
      seg_n      = SEG_SYNC;
      qcnt_n     = '0;
      enter_sync = run;
    end else if (tick) begin
      unique case (seg_q)
        SEG_SYNC: begin
          seg_n  = SEG_TS1;
          qcnt_n = '0;
        end
        SEG_TS1: begin
          ts1_tick = 1'b1;
          if (q_inc >= t1_eff) begin
            seg_n    = SEG_TS2;
            qcnt_n   = '0;
            smp_tick = 1'b1;
          end else begin
            qcnt_n = q_inc;
          end
        end
        SEG_TS2: begin
          if (q_inc >= t2_eff) begin
            seg_n      = SEG_SYNC;
            qcnt_n     = '0;
            enter_sync = 1'b1;
          end else begin
            qcnt_n = q_inc;
          end
        end
        default: seg_n = SEG_SYNC;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= SEG_SYNC;
      qcnt_q <= '0;
      ext_q  <= '0;
      shr_q  <= '0;
      done_q <= 1'b0;
      tx_q   <= 1'b0;
    end else begin
      seg_q  <= seg_n;
      qcnt_q <= qcnt_n;
      tx_q   <= enter_sync;
      if (!run || enter_sync) begin
        ext_q  <= '0;
        shr_q  <= '0;
        done_q <= restart;
      end else begin
        ext_q  <= ext_n;
        shr_q  <= shr_n;
        done_q <= done_n;
      end
    end
  end
endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rx,
  input  logic vote,
  input  logic ts1_tick,
  input  logic smp_tick,
  output logic pt_q,
  output logic val_q
);
  logic [1:0] hist_q, hist_n;
  logic       pt_n, val_n, maj;

  assign maj = (hist_q[1] & hist_q[0]) | (hist_q[1] & rx) | (hist_q[0] & rx);

  always_comb begin
    hist_n = hist_q;
    pt_n   = 1'b0;
    val_n  = val_q;
    if (!run) begin
      hist_n = 2'b11;
    end else begin
      if (ts1_tick) hist_n = {hist_q[0], rx};
      if (smp_tick) begin
        pt_n  = 1'b1;
        val_n = vote ? maj : rx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 2'b11;
      pt_q   <= 1'b0;
      val_q  <= 1'b1;
    end else begin
      hist_q <= hist_n;
      pt_q   <= pt_n;
      val_q  <= val_n;
    end
  end
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
  import can_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_in,
  input  logic             hsync_en,
  input  logic [BRP_W-1:0] brp_cfg,
  input  logic [TS1_W-1:0] ts1_cfg,
  input  logic [TS2_W-1:0] ts2_cfg,
  input  logic [SJW_W-1:0] sjw_cfg,
  input  logic             smp_mode,
  output logic             cfg_err,
  output logic             tx_strobe,
  output logic             smp_strobe,
  output logic             smp_val
);
  logic [1:0] rst_pipe;
  logic       rst_ns;
  logic       rx_d, edge_fall;
  logic       err_q, cfg_ok, run;
  logic       tick, restart, ts1_tick, smp_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  assign cfg_ok = (ts1_cfg >= TS1_W'(TS1_MIN)) &&
                  (ts2_cfg >= TS2_W'(TS2_MIN)) &&
                  (ts2_cfg >= TS2_W'(sjw_cfg)) &&
                  (ts1_cfg >  TS1_W'(ts2_cfg));

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      err_q <= 1'b1;
      rx_d  <= 1'b1;
    end else begin
      err_q <= !cfg_ok;
      rx_d  <= rx_in;
    end
  end

  assign run       = !err_q;
  assign edge_fall = rx_d && !rx_in;
  assign cfg_err   = err_q;

  can_bt_presc u_presc (
    .clk     (clk),
    .rst_n   (rst_ns),
    .run     (run),
    .restart (restart),
    .div     (brp_cfg),
    .tick    (tick)
  );

  can_bt_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_ns),
    .run       (run),
    .tick      (tick),
    .edge_fall (edge_fall),
    .hs_en     (hsync_en),
    .t1_len    (T1_LEN_W'(ts1_cfg) + 1'b1),
    .t2_len    (T2_LEN_W'(ts2_cfg) + 1'b1),
    .sjw_len   (SJW_LEN_W'(sjw_cfg) + 1'b1),
    .restart   (restart),
    .ts1_tick  (ts1_tick),
    .smp_tick  (smp_tick),
    .tx_q      (tx_strobe)
  );

  can_bt_sampler u_smp (
    .clk      (clk),
    .rst_n    (rst_ns),
    .run      (run),
    .rx       (rx_in),
    .vote     (smp_mode),
    .ts1_tick (ts1_tick),
    .smp_tick (smp_tick),
    .pt_q     (smp_strobe),
    .val_q    (smp_val)
  );
endmodule

// File: rtl/can_bt_chk.sv
module can_bt_chk
  import can_bt_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic cfg_err,
  input logic tx_strobe,
  input logic smp_strobe,
  input logic smp_val
);
  localparam int GAP_LIM = 2 * MAX_BIT_CLK;
  localparam int GAP_W   = $clog2(GAP_LIM) + 1;

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     gap_q <= '0;
    else if (tx_strobe || cfg_err)  gap_q <= '0;
    else if (gap_q != '1)           gap_q <= gap_q + 1'b1;
  end

  p_bit_bounded_r1: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q < GAP_W'(GAP_LIM));

  p_strobes_apart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_strobe && smp_strobe));

  p_tx_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |=> !tx_strobe);

  p_quiet_when_bad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> (!tx_strobe && !smp_strobe));

  p_val_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_strobe |-> $stable(smp_val));
endmodule

bind can_bit_timing can_bt_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_err    (cfg_err),
  .tx_strobe  (tx_strobe),
  .smp_strobe (smp_strobe),
  .smp_val    (smp_val)
);

// File: tb/sim_can_bit_timing.sv
`timescale 1ns/1ps
module sim_can_bit_timing;
  import can_bt_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic hs = 1'b0;
  logic [BRP_W-1:0] brp = '0;
  logic [TS1_W-1:0] ts1 = '0;
  logic [TS2_W-1:0] ts2 = '0;
  logic [SJW_W-1:0] sjw = '0;
  logic smode = 1'b0;
  logic cfg_err, tx_strobe, smp_strobe, smp_val;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  can_bit_timing u0 (
    .clk(clk), .rst_n(rst_n), .rx_in(rx), .hsync_en(hs),
    .brp_cfg(brp), .ts1_cfg(ts1), .ts2_cfg(ts2), .sjw_cfg(sjw),
    .smp_mode(smode), .cfg_err(cfg_err), .tx_strobe(tx_strobe),
    .smp_strobe(smp_strobe), .smp_val(smp_val)
  );

  typedef struct packed {
    logic [5:0] b;
    logic [3:0] t1;
    logic [2:0] t2;
    logic [1:0] j;
    logic       bad;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{6'd0,  4'd3,  3'd1, 2'd0, 1'b0},
    '{6'd3,  4'd15, 3'd7, 2'd3, 1'b0},
    '{6'd63, 4'd5,  3'd2, 2'd1, 1'b0},
    '{6'd1,  4'd7,  3'd3, 2'd3, 1'b0},
    '{6'd2,  4'd2,  3'd1, 2'd0, 1'b1},
    '{6'd2,  4'd5,  3'd0, 2'd0, 1'b1},
    '{6'd2,  4'd6,  3'd2, 2'd3, 1'b1},
    '{6'd2,  4'd4,  3'd4, 2'd1, 1'b1},
    '{6'd2,  4'd3,  3'd3, 2'd0, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_tx(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      step();
      if (tx_strobe) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  // starts at a negedge showing tx_strobe; index k counts negedges from there
  task automatic run_bit(input int kf, input int kr, input int kf2,
                         output int dsmp, output int dbit, output int sval);
    dsmp = -1; dbit = -1; sval = -1;
    for (int k = 0; k < 5000; k++) begin
      if (k == kf)  rx = 1'b0;
      if (k == kr)  rx = 1'b1;
      if (k == kf2) rx = 1'b0;
      step();
      if (smp_strobe) begin
        dsmp = k + 1;
        sval = int'(smp_val);
      end
      if (tx_strobe) begin
        dbit = k + 1;
        break;
      end
    end
    rx = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    bit ok;
    int ds, db, sv;
    int q, t1, t2, cnt;

    brp = 6'd3; ts1 = 4'd7; ts2 = 3'd3; sjw = 2'd1;
    repeat (4) step();
    // R11 reset state
    check(tx_strobe == 1'b0, "R11 tx_strobe in reset", int'(tx_strobe), 0);
    check(smp_strobe == 1'b0, "R11 smp_strobe in reset", int'(smp_strobe), 0);
    check(smp_val == 1'b1, "R11 smp_val in reset", int'(smp_val), 1);
    rst_n = 1'b1;

    // table walk: nominal timing and legality
    for (int i = 0; i < 9; i++) begin
      brp = VECS[i].b; ts1 = VECS[i].t1; ts2 = VECS[i].t2; sjw = VECS[i].j;
      smode = 1'b0;
      repeat (4) step();
      check(cfg_err == VECS[i].bad, "R4 cfg_err", int'(cfg_err), int'(VECS[i].bad));
      if (VECS[i].bad) begin
        cnt = 0;
        for (int c = 0; c < 200; c++) begin
          step();
          if (tx_strobe || smp_strobe) cnt++;
        end
        check(cnt == 0, "R4 strobes while illegal", cnt, 0);
      end else begin
        q = int'(VECS[i].b) + 1; t1 = int'(VECS[i].t1) + 1; t2 = int'(VECS[i].t2) + 1;
        wait_tx(ok);
        check(ok, "R1 tx strobe present", int'(ok), 1);
        run_bit(-1, -1, -1, ds, db, sv);
        check(db == (1 + t1 + t2) * q, "R1 bit period", db, (1 + t1 + t2) * q);
        check(ds == (1 + t1) * q, "R2 sample offset", ds, (1 + t1) * q);
        check(sv == 1, "R9 recessive sample", sv, 1);
      end
    end

    // directed: Q=4, T1=8, T2=4, J=2 -> nominal bit 52, sample 36
    brp = 6'd3; ts1 = 4'd7; ts2 = 3'd3; sjw = 2'd1; smode = 1'b0;
    repeat (4) step();
    wait_tx(ok);
    step();
    check(tx_strobe == 1'b0, "R3 tx pulse width", int'(tx_strobe), 0);
    wait_tx(ok);

    run_bit(5, 9, -1, ds, db, sv);      // R5 seg1 q0 -> +1
    check(ds == 40, "R5 small lengthen sample", ds, 40);
    check(db == 56, "R5 small lengthen period", db, 56);

    run_bit(21, 25, -1, ds, db, sv);    // R5 seg1 q4 -> clipped +2
    check(ds == 44, "R5 clipped lengthen sample", ds, 44);
    check(db == 60, "R5 clipped lengthen period", db, 60);

    run_bit(45, -1, -1, ds, db, sv);    // R6 seg2 q2 -> -1
    check(db == 48, "R6 small shorten period", db, 48);
    check(ds == 36, "R6 sample untouched", ds, 36);

    run_bit(37, -1, -1, ds, db, sv);    // R6 seg2 q0 -> clipped -2
    check(db == 44, "R6 clipped shorten period", db, 44);

    run_bit(49, -1, -1, ds, db, sv);    // R6 seg2 last quantum -> none
    check(db == 52, "R6 last quantum edge", db, 52);

    run_bit(5, 9, 37, ds, db, sv);      // R7 second edge ignored
    check(db == 56, "R7 one resync per bit", db, 56);

    run_bit(1, 13, 37, ds, db, sv);     // R7 sync edge free, later edge acts
    check(ds == 36, "R7 sync edge ignored", ds, 36);
    check(db == 44, "R7 sync edge not counted", db, 44);

    run_bit(1, 21, -1, ds, db, sv);     // R12 rising edge only
    check(ds == 36 && db == 52, "R12 rising edge", db, 52);

    hs = 1'b1;
    run_bit(37, -1, -1, ds, db, sv);    // R8 hard sync late in bit
    hs = 1'b0;
    check(db == 38, "R8 hard sync restart", db, 38);
    run_bit(-1, -1, -1, ds, db, sv);
    check(ds == 36 && db == 52, "R8 nominal after restart", db, 52);

    run_bit(1, 33, -1, ds, db, sv);     // R9 single sample sees last quantum
    check(sv == 1, "R9 single sample late pulse", sv, 1);
    run_bit(1, -1, -1, ds, db, sv);
    check(sv == 0, "R9 single sample dominant", sv, 0);

    smode = 1'b1;
    run_bit(1, 33, -1, ds, db, sv);     // R10 votes 0,0,1
    check(sv == 0, "R10 vote outvotes pulse", sv, 0);
    run_bit(1, 29, -1, ds, db, sv);     // R10 votes 0,1,1
    check(sv == 1, "R10 vote two recessive", sv, 1);
    check(db == 52, "R10 timing unchanged", db, 52);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule